// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which of four operating modes a digital PLL is in and, from that mode, which frequency control word (FCW) is sent to the controlled oscillator. The modes are Free-Run, Locked, Holdover and a host-steered oscillator mode (DCO). In Free-Run the word is zero, so the output frequency follows the system clock alone. In Locked the word is the loop filter's output. In Holdover the word is a value averaged while the loop was locked. In DCO the loop is open and an external servo writes the word directly.

The phase detector and loop filter sit outside the block. Only their frequency word and lock flag come in, together with a reference-valid flag and a two-bit host request. While the loop is locked on a valid reference, the block keeps an exponential moving average of the loop word. Once enough samples have been taken, that average is marked usable. A reference that disappears then leads to Holdover rather than Free-Run. Host requests for Free-Run or DCO take priority over every automatic transition.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: During and right after reset the mode is Free-Run (code 0), `fcw_out` is zero and `hold_valid` is low.
- R2: In Free-Run `fcw_out` is zero. Under automatic request, Free-Run moves to Locked (code 1) at the next clock edge only when `ref_valid` and `loop_lock` are both high.
- R3: In Locked `fcw_out` equals `loop_fcw` in the same cycle. Under automatic request the mode stays Locked while `ref_valid` is high, even if `loop_lock` drops.
- R4: A sample is taken on each edge where the mode is Locked and both `ref_valid` and `loop_lock` are high. The first sample after reset loads the average directly. Every later sample adds floor((sample - average) / 2^AVG_SHIFT) to the average. On any other edge the average does not change.
- R5: `hold_valid` rises on the edge that takes the MIN_SAMPLES-th sample (16 by default) and stays high until reset.
- R6: In Locked under automatic request, a low `ref_valid` moves the mode at the next edge to Holdover (code 2) if `hold_valid` is high, and to Free-Run otherwise.
- R7: In Holdover `fcw_out` equals the stored average and does not follow `loop_fcw`.
- R8: Holdover moves to Locked at the next edge once `ref_valid` and `loop_lock` are both high. Otherwise it stays in Holdover.
- R9: `host_req` = 2 forces DCO (code 3) at the next edge from any mode. In DCO `fcw_out` equals `host_dco_fcw` in the same cycle.
- R10: `host_req` = 1 forces Free-Run at the next edge from any mode, and keeps it there whatever the reference and lock flags are.
- R11: `host_req` values 0 and 3 both mean automatic operation. Leaving DCO under automatic request always passes through Free-Run first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Selected reference is qualified |
| loop_lock | input | 1 | Loop reports phase lock |
| loop_fcw | input | FCW_W | Signed frequency word from the loop filter |
| host_req | input | 2 | Mode request: 0/3 automatic, 1 Free-Run, 2 DCO |
| host_dco_fcw | input | FCW_W | Signed frequency word written by the host servo |
| fcw_out | output | FCW_W | Signed frequency word to the oscillator |
| mode_out | output | 2 | Current mode: 0 Free-Run, 1 Locked, 2 Holdover, 3 DCO |
| hold_valid | output | 1 | Stored average is usable for Holdover |

## Verification
Holdover is the hardest state to reach from the ports. It needs at least sixteen locked samples on a valid reference, and only then a loss of reference, so the averaged value it replays depends on the whole history before it. The bench first drops the reference after only a few samples, which must lead to Free-Run. It then relocks and feeds a ramp of loop words while tracking the floor-rounded average in its own model. It also inserts cycles with the lock flag low and a wild loop word, which must leave the average untouched. Finally it removes the reference and compares the replayed word against the model.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_HOLD = 2'd2,
    MODE_DCO  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    REQ_AUTO  = 2'd0,
    REQ_FREE  = 2'd1,
    REQ_DCO   = 2'd2,
    REQ_AUTO3 = 2'd3
  } req_e;

  // Mode transition rule; host requests take priority over automatic moves.
  function automatic mode_e next_mode(input mode_e cur, input req_e req,
                                      input logic ref_ok, input logic lock,
                                      input logic hold_ok);
    mode_e nxt;
    nxt = cur;
    case (req)
      REQ_DCO:  nxt = MODE_DCO;
      REQ_FREE: nxt = MODE_FREE;
      default: begin
        case (cur)
          MODE_FREE: nxt = (ref_ok && lock) ? MODE_LOCK : MODE_FREE;
          MODE_LOCK: begin
            if (!ref_ok) nxt = hold_ok ? MODE_HOLD : MODE_FREE;
            else         nxt = MODE_LOCK;
          end
          MODE_HOLD: nxt = (ref_ok && lock) ? MODE_LOCK : MODE_HOLD;
          default:   nxt = MODE_FREE;
        endcase
      end
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  req_e  req,
  input  logic  ref_valid,
  input  logic  loop_lock,
  input  logic  hold_ok,
  output mode_e mode_q,
  output logic  smp_en
);

  mode_e mode_d;

  always_comb begin
    mode_d = next_mode(mode_q, req, ref_valid, loop_lock, hold_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_FREE;
    else        mode_q <= mode_d;
  end

  // Averaging strobe: locked, reference good, loop locked.
  assign smp_en = (mode_q == MODE_LOCK) && ref_valid && loop_lock;

endmodule

// File: rtl/dpll_holdover_avg.sv
module dpll_holdover_avg #(
  parameter int FCW_W       = 32,
  parameter int AVG_SHIFT   = 3,
  parameter int MIN_SAMPLES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [FCW_W-1:0] sample,
  output logic signed [FCW_W-1:0] avg_q,
  output logic                    hold_valid
);

  localparam int CNT_W = $clog2(MIN_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_SAMPLES);

  logic [CNT_W-1:0]        cnt_q;
  logic signed [FCW_W-1:0] avg_d;
  logic                    first_smp;

  // One averaging step computed one bit wider so the difference cannot wrap.
  function automatic logic signed [FCW_W-1:0] ema_step(
      input logic signed [FCW_W-1:0] cur, input logic signed [FCW_W-1:0] x);
    logic signed [FCW_W:0] diff;
    logic signed [FCW_W:0] inc;
    logic signed [FCW_W:0] sum;
    diff = {x[FCW_W-1], x} - {cur[FCW_W-1], cur};
    inc  = diff >>> AVG_SHIFT;
    sum  = {cur[FCW_W-1], cur} + inc;
    return sum[FCW_W-1:0];
  endfunction

  assign first_smp = (cnt_q == '0);

  generate
    if (AVG_SHIFT == 0) begin : g_track
      assign avg_d = sample;
    end else begin : g_ema
      assign avg_d = first_smp ? sample : ema_step(avg_q, sample);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg_q <= '0;
      cnt_q <= '0;
    end else if (smp_en) begin
      avg_q <= avg_d;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hold_valid = (cnt_q == CNT_MAX);

endmodule

// File: rtl/dpll_fcw_select.sv
module dpll_fcw_select
  import dpll_mode_pkg::*;
#(
  parameter int FCW_W = 32
) (
  input  mode_e                   mode,
  input  logic signed [FCW_W-1:0] loop_fcw,
  input  logic signed [FCW_W-1:0] hold_fcw,
  input  logic signed [FCW_W-1:0] dco_fcw,
  output logic signed [FCW_W-1:0] fcw
);

  always_comb begin
    case (mode)
      MODE_LOCK: fcw = loop_fcw;
      MODE_HOLD: fcw = hold_fcw;
      MODE_DCO:  fcw = dco_fcw;
      default:   fcw = '0;
    endcase
  end

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int FCW_W       = 32,
  parameter int AVG_SHIFT   = 3,
  parameter int MIN_SAMPLES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_valid,
  input  logic                    loop_lock,
  input  logic signed [FCW_W-1:0] loop_fcw,
  input  logic [1:0]              host_req,
  input  logic signed [FCW_W-1:0] host_dco_fcw,
  output logic signed [FCW_W-1:0] fcw_out,
  output logic [1:0]              mode_out,
  output logic                    hold_valid
);

  mode_e                   mode_q;
  logic                    avg_upd;
  logic signed [FCW_W-1:0] avg_q;
  req_e                    req;

  assign req = req_e'(host_req);

  dpll_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .ref_valid (ref_valid),
    .loop_lock (loop_lock),
    .hold_ok   (hold_valid),
    .mode_q    (mode_q),
    .smp_en    (avg_upd)
  );

  dpll_holdover_avg #(
    .FCW_W       (FCW_W),
    .AVG_SHIFT   (AVG_SHIFT),
    .MIN_SAMPLES (MIN_SAMPLES)
  ) u_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (avg_upd),
    .sample     (loop_fcw),
    .avg_q      (avg_q),
    .hold_valid (hold_valid)
  );

  dpll_fcw_select #(.FCW_W(FCW_W)) u_sel (
    .mode     (mode_q),
    .loop_fcw (loop_fcw),
    .hold_fcw (avg_q),
    .dco_fcw  (host_dco_fcw),
    .fcw      (fcw_out)
  );

  assign mode_out = mode_q;

endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk #(
  parameter int FCW_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_valid,
  input logic [1:0]              host_req,
  input logic signed [FCW_W-1:0] fcw_out,
  input logic [1:0]              mode_out,
  input logic                    hold_valid,
  input logic                    avg_upd,
  input logic signed [FCW_W-1:0] avg_q
);

  // R2
  free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out == 2'd0 |-> fcw_out == '0);

  // R3
  lock_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'd1 && ref_valid && (host_req == 2'd0 || host_req == 2'd3))
      |=> mode_out == 2'd1);

  // R4
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_upd |=> $stable(avg_q));

  // R5
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |=> hold_valid);

  // R6
  hold_needs_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out == 2'd2 |-> hold_valid);

  // R7
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out == 2'd2 |=> (mode_out != 2'd2 || $stable(fcw_out)));

  // R9
  force_dco_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req == 2'd2 |=> mode_out == 2'd3);

  // R10
  force_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req == 2'd1 |=> mode_out == 2'd0);

endmodule

bind dpll_mode_ctrl dpll_mode_chk #(.FCW_W(FCW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_valid  (ref_valid),
  .host_req   (host_req),
  .fcw_out    (fcw_out),
  .mode_out   (mode_out),
  .hold_valid (hold_valid),
  .avg_upd    (avg_upd),
  .avg_q      (avg_q)
);

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               ref_valid;
  logic               loop_lock;
  logic signed [31:0] loop_fcw;
  logic [1:0]         host_req;
  logic signed [31:0] host_dco_fcw;
  wire signed [31:0]  fcw_out;
  wire [1:0]          mode_out;
  wire                hold_valid;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  longint m_avg = 0;
  int    m_cnt  = 0;

  always #4 clk = ~clk;

  dpll_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .loop_lock(loop_lock),
    .loop_fcw(loop_fcw), .host_req(host_req), .host_dco_fcw(host_dco_fcw),
    .fcw_out(fcw_out), .mode_out(mode_out), .hold_valid(hold_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint floor_div(input longint d, input longint k);
    longint q;
    q = d / k;
    if ((d % k) != 0 && d < 0) q = q - 1;
    return q;
  endfunction

  task automatic model_sample(input longint x);
    if (m_cnt == 0) m_avg = x;
    else            m_avg = m_avg + floor_div(x - m_avg, 8);
    if (m_cnt < 16) m_cnt++;
  endtask

  // Advance one edge; smp tells the model whether this edge takes a sample.
  task automatic step(input bit smp);
    @(posedge clk);
    if (smp) model_sample(longint'(loop_fcw));
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; ref_valid = 0; loop_lock = 0; loop_fcw = 123;
    host_req = 0; host_dco_fcw = 0;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", mode_out, 0);
    chk("R1 fcw in reset", fcw_out, 0);
    rst_n = 1;
    step(0);
    chk("R1 mode after reset", mode_out, 0);
    chk("R1 hold_valid after reset", hold_valid, 0);
  endtask

  task automatic t_freerun();
    ref_valid = 0; loop_lock = 1; loop_fcw = 555;
    repeat (3) step(0);
    chk("R2 stays free without ref", mode_out, 0);
    chk("R2 fcw zero in free-run", fcw_out, 0);
    ref_valid = 1; loop_lock = 0;
    repeat (2) step(0);
    chk("R2 stays free without lock", mode_out, 0);
  endtask

  task automatic t_lock_entry();
    loop_lock = 1; loop_fcw = 1000;
    step(0);
    chk("R2 enters locked", mode_out, 1);
    chk("R3 fcw follows loop", fcw_out, 1000);
    loop_fcw = 1100;
    #1;
    chk("R3 fcw follows loop same cycle", fcw_out, 1100);
    for (int i = 0; i < 3; i++) begin
      loop_fcw = 32'(1100 + i * 10);
      step(1);
    end
    chk("R5 not valid after 3 samples", hold_valid, 0);
  endtask

  task automatic t_lost_early();
    ref_valid = 0; loop_lock = 0;
    step(0);
    chk("R6 no average goes free", mode_out, 0);
    chk("R6 fcw zero", fcw_out, 0);
  endtask

  task automatic t_gather();
    ref_valid = 1; loop_lock = 1; loop_fcw = -4000;
    step(0);
    chk("R8 relock from free", mode_out, 1);
    for (int i = 0; i < 20; i++) begin
      loop_fcw = 32'(-4000 + i * 37);
      step(1);
      if (m_cnt == 16 || i == 0)
        chk("R5 hold_valid after samples", hold_valid, (m_cnt >= 16) ? 1 : 0);
    end
    loop_lock = 0; loop_fcw = 999999;
    repeat (4) step(0);
    chk("R3 stays locked with lock low", mode_out, 1);
  endtask

  task automatic t_holdover();
    ref_valid = 0; loop_fcw = 77777;
    step(0);
    chk("R6 enters holdover", mode_out, 2);
    chk("R4 holdover word equals average", fcw_out, m_avg);
    loop_fcw = -5;
    repeat (3) step(0);
    chk("R7 holdover ignores loop word", fcw_out, m_avg);
  endtask

  task automatic t_return();
    ref_valid = 1; loop_lock = 0;
    step(0);
    chk("R8 stays holdover without lock", mode_out, 2);
    loop_lock = 1; loop_fcw = 2222;
    step(0);
    chk("R8 returns to locked", mode_out, 1);
    chk("R3 fcw follows loop after return", fcw_out, 2222);
  endtask

  task automatic t_dco();
    host_req = 2; host_dco_fcw = -12345;
    step(1);
    chk("R9 forced dco", mode_out, 3);
    chk("R9 dco word", fcw_out, -12345);
    host_dco_fcw = 42;
    #1;
    chk("R9 dco word tracks host", fcw_out, 42);
    repeat (2) step(0);
    chk("R9 stays dco with ref and lock", mode_out, 3);
    host_req = 0;
    step(0);
    chk("R11 leaving dco goes free", mode_out, 0);
    step(0);
    chk("R11 then relocks", mode_out, 1);
  endtask

  task automatic t_force_free();
    host_req = 1;
    step(1);
    chk("R10 forced free", mode_out, 0);
    chk("R10 fcw zero", fcw_out, 0);
    repeat (3) step(0);
    chk("R10 held free with ref and lock", mode_out, 0);
    host_req = 3;
    step(0);
    chk("R11 code 3 is automatic", mode_out, 1);
    ref_valid = 0; loop_lock = 0;
    step(0);
    chk("R6 holdover again", mode_out, 2);
    chk("R4 average carried through", fcw_out, m_avg);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_freerun();
    t_lock_entry();
    t_lost_early();
    t_gather();
    t_holdover();
    t_return();
    t_dco();
    t_force_free();
    finish_run();
  end

endmodule